// File: doc/BRIEF.md
# Cell-Threshold Transmit Start FIFO

This block buffers outgoing packet bytes between a memory-fetch engine and a MAC transmitter. Its storage holds 24 cells of 64 bytes (1536 bytes). The write side pushes bytes with an end-of-packet marker and sees backpressure once every cell is in use. The read side is a pull interface driven by the MAC. The MAC may open a new packet only while the block raises a start-permitted flag.

The start flag rises when one of two conditions holds. Either the buffered byte count reaches the programmed number of full cells, or a complete packet is held. Gating on cells rather than on non-empty means a packet no longer than the threshold times 64 bytes can never run dry on the wire. A threshold of 24 holds back any packet that is still short of its end marker until a full maximum-size packet is stored.

If the MAC pulls a byte in the middle of a packet while the FIFO is empty, the block pulses an underrun flag. It then silently drops the rest of that packet, up to and including its end marker, and goes back to waiting for the next start.

Top module: `txf_top`

## Requirements
- R1: The FIFO holds 1536 bytes. `wr_ready` is high until 1536 bytes are buffered and then goes low. A write offered while `wr_ready` is low is not stored. `wr_ready` rises again after one byte is read.
- R2: After a synchronous reset, `wr_ready` is 1 and `tx_start_ok`, `rd_valid`, `rd_last` and `underrun` are 0.
- R3: While idle, `tx_start_ok` is high in the cycle after the buffered byte count reaches threshold×64, even when no end marker has been written.
- R4: While idle, `tx_start_ok` is high in the cycle after a byte with `wr_last`=1 is accepted, even below the threshold.
- R5: A threshold value of 0 acts as 1. Any value above 24 acts as 24.
- R6: When `rd_req` is sampled high while idle with `tx_start_ok`=1, or while sending, one byte is removed. In the next cycle it appears on `rd_data` with `rd_valid`=1, in write order, and `rd_last`=1 marks the end-of-packet byte.
- R7: `tx_start_ok` is low from the cycle after a packet's first byte is read until its last byte is read. It is then set again from the current occupancy for the next packet.
- R8: If `rd_req` is high while sending and the FIFO is empty before that edge, `underrun` is high for exactly one cycle and `rd_valid` stays low. Every remaining byte of that packet, up to and including its end marker, is removed without `rd_valid`. The following packet is then delivered normally.
- R9: `rd_req` while idle with `tx_start_ok`=0 removes nothing and leaves `rd_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cells_thresh | input | 5 | Start threshold in full cells, 1 to 24 |
| wr_valid | input | 1 | Write byte offered |
| wr_data | input | 8 | Write byte |
| wr_last | input | 1 | Offered byte ends its packet |
| wr_ready | output | 1 | Space available; write accepted when high |
| rd_req | input | 1 | MAC pulls one byte |
| rd_valid | output | 1 | `rd_data` carries a delivered byte |
| rd_data | output | 8 | Delivered byte |
| rd_last | output | 1 | Delivered byte ends its packet |
| tx_start_ok | output | 1 | A new packet may be started |
| underrun | output | 1 | One-cycle pulse: FIFO ran dry mid-packet |

## Verification
Two things can meet in one edge. The MAC can request a byte mid-packet while the FIFO is empty, and in that same edge the writer can deliver the missing end-of-packet byte. The bench provokes this by draining a 64-byte packet that has no end marker, then raising `rd_req` together with a `wr_valid`/`wr_last` write. The expected result follows from the occupancy before the edge: `underrun` pulses, and the just-written byte is dropped as the remainder of the failed packet with `rd_valid` held low. A following four-byte packet must then be gated and delivered intact.

// File: rtl/txf_pkg.sv
package txf_pkg;
  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_SEND = 2'd1,
    RS_DROP = 2'd2
  } rd_state_e;
endpackage

// File: rtl/txf_store.sv
module txf_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 1536
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              push_last,
  input  logic              pop,
  output logic [DATA_W-1:0] pop_data,
  output logic              head_last
);
  localparam int AW = $clog2(DEPTH);

  logic [DATA_W-1:0] data_mem [DEPTH];
  logic              last_mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;

  // byte storage: synchronous write and registered read (block RAM)
  always_ff @(posedge clk) begin
    if (push) data_mem[wptr] <= push_data;
    if (pop)  pop_data <= data_mem[rptr];
  end

  // end markers kept apart so the head marker is visible before the pop
  always_ff @(posedge clk) begin
    if (push) last_mem[wptr] <= push_last;
  end
  assign head_last = last_mem[rptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
    end
  end
endmodule

// File: rtl/txf_occupancy.sv
module txf_occupancy #(
  parameter int NUM_CELLS  = 24,
  parameter int CELL_BYTES = 64
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           push,
  input  logic                           push_last,
  input  logic                           pop,
  input  logic                           pop_last,
  input  logic [$clog2(NUM_CELLS+1)-1:0] thresh,
  output logic                           full,
  output logic                           empty,
  output logic                           gate_next
);
  localparam int DEPTH = NUM_CELLS * CELL_BYTES;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int TW    = $clog2(NUM_CELLS + 1);

  logic [CW-1:0] byte_cnt, pkt_cnt, byte_n, pkt_n, need_bytes;
  logic [TW-1:0] thr_eff;

  always_comb begin
    if (thresh == '0)                   thr_eff = TW'(1);
    else if (thresh > TW'(NUM_CELLS))   thr_eff = TW'(NUM_CELLS);
    else                                thr_eff = thresh;
    need_bytes = CW'(thr_eff) * CW'(CELL_BYTES);
    byte_n = byte_cnt + CW'(push) - CW'(pop);
    pkt_n  = pkt_cnt + CW'(push && push_last) - CW'(pop && pop_last);
    gate_next = (pkt_n != '0) || (byte_n >= need_bytes);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_cnt <= '0;
      pkt_cnt  <= '0;
    end else begin
      byte_cnt <= byte_n;
      pkt_cnt  <= pkt_n;
    end
  end

  assign full  = (byte_cnt == CW'(DEPTH));
  assign empty = (byte_cnt == '0);

  assert_no_overflow_R1: assert property (@(posedge clk) disable iff (rst)
    byte_cnt <= CW'(DEPTH)) else $error("byte count above capacity");
  assert_pkts_within_bytes_R4: assert property (@(posedge clk) disable iff (rst)
    pkt_cnt <= byte_cnt) else $error("more packets than bytes");
endmodule

// File: rtl/txf_read_fsm.sv
module txf_read_fsm
  import txf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rd_req,
  input  logic empty,
  input  logic head_last,
  input  logic gate_next,
  output logic pop,
  output logic start_ok,
  output logic rd_valid,
  output logic rd_last,
  output logic underrun
);
  rd_state_e state, state_n;

  always_comb begin
    pop     = 1'b0;
    state_n = state;
    unique case (state)
      RS_IDLE: begin
        pop = rd_req && start_ok && !empty;
        if (pop && !head_last) state_n = RS_SEND;
      end
      RS_SEND: begin
        pop = rd_req && !empty;
        if (rd_req && empty)       state_n = RS_DROP;
        else if (pop && head_last) state_n = RS_IDLE;
      end
      RS_DROP: begin
        pop = !empty;
        if (pop && head_last) state_n = RS_IDLE;
      end
      default: state_n = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= RS_IDLE;
      start_ok <= 1'b0;
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
      underrun <= 1'b0;
    end else begin
      state    <= state_n;
      start_ok <= (state_n == RS_IDLE) && gate_next;
      rd_valid <= pop && (state != RS_DROP);
      rd_last  <= pop && (state != RS_DROP) && head_last;
      underrun <= (state == RS_SEND) && rd_req && empty;
    end
  end

  assert_underrun_single_R8: assert property (@(posedge clk) disable iff (rst)
    underrun |=> !underrun) else $error("underrun longer than one cycle");
  assert_underrun_no_data_R8: assert property (@(posedge clk) disable iff (rst)
    underrun |-> !rd_valid) else $error("byte delivered with underrun");
  assert_no_start_midpacket_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_last) |-> !start_ok) else $error("start allowed mid-packet");
  assert_idle_req_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (state == RS_IDLE && !start_ok && rd_req) |=> !rd_valid)
    else $error("byte delivered without start permission");
endmodule

// File: rtl/txf_top.sv
module txf_top #(
  parameter int NUM_CELLS  = 24,
  parameter int CELL_BYTES = 64,
  parameter int DATA_W     = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [$clog2(NUM_CELLS+1)-1:0] cfg_cells_thresh,
  input  logic                           wr_valid,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic                           wr_last,
  output logic                           wr_ready,
  input  logic                           rd_req,
  output logic                           rd_valid,
  output logic [DATA_W-1:0]              rd_data,
  output logic                           rd_last,
  output logic                           tx_start_ok,
  output logic                           underrun
);
  localparam int DEPTH = NUM_CELLS * CELL_BYTES;

  logic full, empty, push, pop, head_last, gate_next;

  assign wr_ready = !full;
  assign push     = wr_valid && !full;

  txf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst),
    .push(push), .push_data(wr_data), .push_last(wr_last),
    .pop(pop), .pop_data(rd_data), .head_last(head_last)
  );

  txf_occupancy #(.NUM_CELLS(NUM_CELLS), .CELL_BYTES(CELL_BYTES)) u_occ (
    .clk(clk), .rst(rst),
    .push(push), .push_last(wr_last),
    .pop(pop), .pop_last(head_last),
    .thresh(cfg_cells_thresh),
    .full(full), .empty(empty), .gate_next(gate_next)
  );

  txf_read_fsm u_fsm (
    .clk(clk), .rst(rst),
    .rd_req(rd_req), .empty(empty), .head_last(head_last),
    .gate_next(gate_next), .pop(pop),
    .start_ok(tx_start_ok), .rd_valid(rd_valid),
    .rd_last(rd_last), .underrun(underrun)
  );

  assert_start_has_data_R3: assert property (@(posedge clk) disable iff (rst)
    tx_start_ok |-> !empty) else $error("start allowed with empty FIFO");
endmodule

// File: tb/test_txf_top.sv
module test_txf_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] thr = 5'd1;
  logic       wr_valid = 1'b0, wr_last = 1'b0, rd_req = 1'b0;
  logic [7:0] wr_data = '0;
  logic       wr_ready, rd_valid, rd_last, tx_start_ok, underrun;
  logic [7:0] rd_data;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  txf_top i_txf_top (
    .clk(clk), .rst(rst), .cfg_cells_thresh(thr),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_last(wr_last), .wr_ready(wr_ready),
    .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last),
    .tx_start_ok(tx_start_ok), .underrun(underrun)
  );

  typedef struct packed {
    logic [7:0]  t;
    logic [15:0] n;
    logic        fin;
    logic        exp;
  } vec_t;

  // gate vectors: R3 cell count, R4 whole packet, R5 threshold clamping
  localparam vec_t VECS [14] = '{
    '{8'd2,  16'd127,  1'b0, 1'b0}, '{8'd2,  16'd128,  1'b0, 1'b1},
    '{8'd1,  16'd63,   1'b0, 1'b0}, '{8'd1,  16'd64,   1'b0, 1'b1},
    '{8'd3,  16'd191,  1'b0, 1'b0}, '{8'd3,  16'd192,  1'b0, 1'b1},
    '{8'd24, 16'd1535, 1'b0, 1'b0}, '{8'd24, 16'd1536, 1'b0, 1'b1},
    '{8'd24, 16'd10,   1'b1, 1'b1}, '{8'd5,  16'd300,  1'b1, 1'b1},
    '{8'd0,  16'd63,   1'b0, 1'b0}, '{8'd0,  16'd64,   1'b0, 1'b1},
    '{8'd31, 16'd1535, 1'b0, 1'b0}, '{8'd31, 16'd1536, 1'b0, 1'b1}
  };

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_valid = 1'b0; wr_last = 1'b0; rd_req = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic push_bytes(int n, bit with_last, logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      wr_valid = 1'b1;
      wr_data  = seed + 8'(i);
      wr_last  = with_last && (i == n - 1);
      @(negedge clk);
    end
    wr_valid = 1'b0; wr_last = 1'b0;
  endtask

  task automatic pull_bytes(int n, logic [7:0] seed, bit end_last);
    rd_req = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R6", "rd_valid", int'(rd_valid), 1);
      chk("R6", "rd_data", int'(rd_data), int'(seed + 8'(i)));
      chk("R6", "rd_last", int'(rd_last), int'(end_last && (i == n - 1)));
      if (i == n - 1) rd_req = 1'b0;
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R6 watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    // R2 reset state
    do_reset();
    chk("R2", "wr_ready", int'(wr_ready), 1);
    chk("R2", "tx_start_ok", int'(tx_start_ok), 0);
    chk("R2", "rd_valid", int'(rd_valid), 0);
    chk("R2", "rd_last", int'(rd_last), 0);
    chk("R2", "underrun", int'(underrun), 0);

    // table walk: start gate after writing n bytes
    foreach (VECS[k]) begin
      string tag;
      do_reset();
      thr = VECS[k].t[4:0];
      tag = (VECS[k].t == 0 || VECS[k].t > 24) ? "R5" : (VECS[k].fin ? "R4" : "R3");
      push_bytes(int'(VECS[k].n), VECS[k].fin, 8'(k));
      chk(tag, "tx_start_ok", int'(tx_start_ok), int'(VECS[k].exp));
    end

    // R1 capacity, refused write, then underrun on an unterminated packet
    do_reset();
    thr = 5'd24;
    push_bytes(1536, 1'b0, 8'h00);
    chk("R1", "wr_ready full", int'(wr_ready), 0);
    wr_valid = 1'b1; wr_data = 8'hEE; wr_last = 1'b1;
    repeat (2) @(negedge clk);
    wr_valid = 1'b0; wr_last = 1'b0;
    pull_bytes(1536, 8'h00, 1'b0);
    chk("R1", "wr_ready drained", int'(wr_ready), 1);
    rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    chk("R1", "refused write absent (underrun)", int'(underrun), 1);
    chk("R8", "rd_valid at underrun", int'(rd_valid), 0);

    // R9 idle requests without permission; R6/R7 ordered delivery
    do_reset();
    thr = 5'd24;
    rd_req = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R9", "rd_valid empty idle", int'(rd_valid), 0);
    end
    rd_req = 1'b0;
    push_bytes(3, 1'b0, 8'h20);
    rd_req = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R9", "rd_valid below threshold", int'(rd_valid), 0);
    end
    rd_req = 1'b0;
    push_bytes(2, 1'b1, 8'h23);
    push_bytes(3, 1'b1, 8'h80);
    chk("R4", "tx_start_ok two packets", int'(tx_start_ok), 1);
    pull_bytes(1, 8'h20, 1'b0);
    chk("R7", "tx_start_ok mid-packet", int'(tx_start_ok), 0);
    pull_bytes(4, 8'h21, 1'b1);
    chk("R7", "tx_start_ok next packet", int'(tx_start_ok), 1);
    pull_bytes(3, 8'h80, 1'b1);
    chk("R7", "tx_start_ok after drain", int'(tx_start_ok), 0);
    @(negedge clk);
    chk("R6", "rd_valid idle", int'(rd_valid), 0);

    // R8 underrun in the same edge as the end-marker write
    do_reset();
    thr = 5'd1;
    push_bytes(64, 1'b0, 8'h10);
    chk("R3", "tx_start_ok one cell", int'(tx_start_ok), 1);
    pull_bytes(64, 8'h10, 1'b0);
    rd_req = 1'b1; wr_valid = 1'b1; wr_data = 8'hAB; wr_last = 1'b1;
    @(negedge clk);
    rd_req = 1'b0; wr_valid = 1'b0; wr_last = 1'b0;
    chk("R8", "underrun pulse", int'(underrun), 1);
    chk("R8", "rd_valid at underrun", int'(rd_valid), 0);
    @(negedge clk);
    chk("R8", "underrun one cycle", int'(underrun), 0);
    chk("R8", "dropped byte hidden", int'(rd_valid), 0);
    chk("R8", "tx_start_ok after drop", int'(tx_start_ok), 0);
    @(negedge clk);
    push_bytes(4, 1'b1, 8'h40);
    chk("R8", "tx_start_ok next packet", int'(tx_start_ok), 1);
    pull_bytes(4, 8'h40, 1'b1);
    chk("R8", "underrun quiet", int'(underrun), 0);

    finish_run();
  end
endmodule